// File: doc/BRIEF.md
# SDA Hold and Setup Timing Stage

This block sits between the bit-level controller of a two-wire serial engine and the SDA pin. The controller stages the next bit to send with a load strobe and releases it with a go strobe, and it reports each SCL falling edge it produces. The block does not let SDA take the staged value until a minimum hold window has passed since the last SCL fall. The window is 3 system clocks in standard timing and 12 in extended timing. Extended timing is typically chosen when the system clock runs above about 10 MHz, so that SDA still meets a 300 ns hold and a 250 ns setup target.

Some bits need a guaranteed setup window before SCL rises: an acknowledge bit and the first, most significant bit of every data byte. The controller marks these as setup-class bits when it loads them. In extended timing the block keeps its ready output low for 11 system clocks after SDA takes such a bit. This stretches the SCL low phase until the count completes. Any wait between load and go adds to that window, and it adds nothing when both strobes arrive in the same cycle. In standard timing the setup margin comes from the SCL low time itself, so ready follows SDA at once.

SDA is an open-drain output: a 1 releases the line and a 0 pulls it low. Reset releases SDA and withdraws ready.

Top module: `sda_hold_setup_timer`

## Requirements
- R1: While reset is high, and after it is released with no other stimulus, sdaOut is 1 (released) and sclReady is 0.
- R2: With extTiming=0, a go-released bit reaches sdaOut no earlier than the third clock edge after the edge that samples sclFall. With go already pending, it reaches sdaOut exactly at that edge.
- R3: With extTiming=1, the same window is 12 clock edges.
- R4: With extTiming=1 and setupClass=1, sclReady stays 0 after sdaOut takes the bit and rises at the 11th edge after that change.
- R5: With extTiming=0, or with setupClass=0, sclReady rises at the same edge at which sdaOut takes the bit.
- R6: A bit whose go is sampled at edge Eg reaches sdaOut at Eg+1, or at the end of the hold window if that comes later. When load and go share a cycle, they add no delay.
- R7: A go strobe with no bit loaded has no effect: sdaOut and sclReady keep their values.
- R8: The edge that samples sclFall drops sclReady to 0. A further sclFall during a hold window restarts the window from that edge.
- R9: When the controller loads more than one bit before go, the most recently loaded value is the one driven.
- R10: An sclFall during an unfinished setup window abandons it. sclReady stays 0 until a new bit is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| extTiming | input | 1 | 1 selects the extended hold and setup profile |
| sclFall | input | 1 | One-cycle pulse: the controller has driven SCL low |
| txBit | input | 1 | Bit value to stage |
| setupClass | input | 1 | Staged bit is an acknowledge bit or a byte MSB |
| bitLoad | input | 1 | Stage txBit and setupClass |
| bitGo | input | 1 | Release the staged bit to the line |
| sdaOut | output | 1 | SDA drive level (1 = released) |
| sclReady | output | 1 | SCL may be released high |

## Verification
Each result has a known edge at which it is due, counted from the edge that samples its cause. That cause is the sclFall edge for the hold window (3 or 12 edges), the go edge plus one, and the SDA change for ready (0 or 11 edges later). Inputs change on falling clock edges and outputs are read one time unit after each rising edge. Every edge is numbered from the stimulus edge, and the bench records the first edge on which sdaOut or sclReady takes its new value. That edge number is compared with the count the requirements give, so an early change fails as surely as a late one.

// File: rtl/sda_timing_pkg.sv
package sda_timing_pkg;

  // Strobes from the control to the datapath, one cycle wide.
  typedef struct packed {
    logic fallSeen;   // SCL fall sampled this cycle
    logic applyNow;   // move staged bit onto SDA at this edge
  } sdaStrobes_t;

endpackage

// File: rtl/sda_timing_ctrl.sv
module sda_timing_ctrl
  import sda_timing_pkg::*;
#(
  parameter int HOLD_STD  = 3,
  parameter int HOLD_EXT  = 12,
  parameter int SETUP_EXT = 11,
  parameter int CNT_W     = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        extTiming,
  input  logic        sclFall,
  input  logic        pendGo,
  input  logic        pendSetup,
  output sdaStrobes_t strobes,
  output logic        setupDone
);

  logic [CNT_W-1:0] holdCnt;
  logic [CNT_W-1:0] setupCnt;
  logic             holdOpen;

  // Apply is allowed on the edge where the hold count runs out.
  assign holdOpen         = (holdCnt <= CNT_W'(1));
  assign strobes.fallSeen = sclFall;
  assign strobes.applyNow = pendGo && holdOpen && !sclFall;
  assign setupDone        = (setupCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      holdCnt <= '0;
    end else if (sclFall) begin
      holdCnt <= extTiming ? CNT_W'(HOLD_EXT) : CNT_W'(HOLD_STD);
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      setupCnt <= '0;
    end else if (sclFall) begin
      setupCnt <= '0;
    end else if (strobes.applyNow) begin
      setupCnt <= (extTiming && pendSetup) ? CNT_W'(SETUP_EXT) : '0;
    end else if (setupCnt != '0) begin
      setupCnt <= setupCnt - CNT_W'(1);
    end
  end

  // R3: every sampled SCL fall starts the hold window selected by the profile
  assert_hold_reload_R3: assert property (@(posedge clk) disable iff (rst)
    sclFall |=> (holdCnt == ($past(extTiming) ? CNT_W'(HOLD_EXT) : CNT_W'(HOLD_STD))));

  // R2: the hold count moves down by one per cycle until it empties
  assert_hold_countdown_R2: assert property (@(posedge clk) disable iff (rst)
    (!sclFall && holdCnt != '0) |=> (holdCnt == $past(holdCnt) - CNT_W'(1)));

  // R4: a running setup window drains one per cycle
  assert_setup_countdown_R4: assert property (@(posedge clk) disable iff (rst)
    (!sclFall && !strobes.applyNow && setupCnt != '0) |=> (setupCnt == $past(setupCnt) - CNT_W'(1)));

  // R10: an SCL fall abandons any setup window
  assert_setup_abandon_R10: assert property (@(posedge clk) disable iff (rst)
    sclFall |=> setupDone);

endmodule

// File: rtl/sda_timing_dp.sv
module sda_timing_dp
  import sda_timing_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  sdaStrobes_t strobes,
  input  logic        txBit,
  input  logic        setupClass,
  input  logic        bitLoad,
  input  logic        bitGo,
  output logic        pendGo,
  output logic        pendSetup,
  output logic        sdaLevel,
  output logic        applied
);

  logic pendBit;
  logic pendValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendBit   <= 1'b1;
      pendSetup <= 1'b0;
      pendValid <= 1'b0;
      pendGo    <= 1'b0;
      sdaLevel  <= 1'b1;
      applied   <= 1'b0;
    end else begin
      if (strobes.applyNow) begin
        sdaLevel  <= pendBit;
        applied   <= 1'b1;
        pendValid <= 1'b0;
        pendGo    <= 1'b0;
      end
      if (bitLoad) begin
        pendBit   <= txBit;
        pendSetup <= setupClass;
        pendValid <= 1'b1;
      end
      if (bitGo && (pendValid || bitLoad)) begin
        pendGo <= 1'b1;
      end
      if (strobes.fallSeen) begin
        applied <= 1'b0;
      end
    end
  end

  // R1: reset releases the line and withdraws the applied flag
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (sdaLevel && !applied));

  // R2: SDA moves only on an apply strobe from the control
  assert_sda_guarded_R2: assert property (@(posedge clk) disable iff (rst)
    !strobes.applyNow |=> $stable(sdaLevel));

  // R7: a go with nothing staged leaves no release pending
  assert_go_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (bitGo && !pendValid && !bitLoad && !pendGo) |=> !pendGo);

  // R8: an SCL fall clears the applied flag
  assert_fall_clears_R8: assert property (@(posedge clk) disable iff (rst)
    strobes.fallSeen |=> !applied);

endmodule

// File: rtl/sda_hold_setup_timer.sv
module sda_hold_setup_timer
  import sda_timing_pkg::*;
#(
  parameter int HOLD_STD  = 3,
  parameter int HOLD_EXT  = 12,
  parameter int SETUP_EXT = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic extTiming,
  input  logic sclFall,
  input  logic txBit,
  input  logic setupClass,
  input  logic bitLoad,
  input  logic bitGo,
  output logic sdaOut,
  output logic sclReady
);

  localparam int MAX_CNT = (HOLD_EXT > SETUP_EXT) ? HOLD_EXT : SETUP_EXT;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  sdaStrobes_t strobes;
  logic        pendGo;
  logic        pendSetup;
  logic        setupDone;
  logic        applied;

  sda_timing_ctrl #(
    .HOLD_STD (HOLD_STD),
    .HOLD_EXT (HOLD_EXT),
    .SETUP_EXT(SETUP_EXT),
    .CNT_W    (CNT_W)
  ) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .extTiming(extTiming),
    .sclFall  (sclFall),
    .pendGo   (pendGo),
    .pendSetup(pendSetup),
    .strobes  (strobes),
    .setupDone(setupDone)
  );

  sda_timing_dp uDp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .txBit     (txBit),
    .setupClass(setupClass),
    .bitLoad   (bitLoad),
    .bitGo     (bitGo),
    .pendGo    (pendGo),
    .pendSetup (pendSetup),
    .sdaLevel  (sdaOut),
    .applied   (applied)
  );

  assign sclReady = applied && setupDone;

  // R5: ready is never offered while the line is still waiting for its bit
  assert_ready_after_apply_R5: assert property (@(posedge clk) disable iff (rst)
    (sclFall && !sclReady) |=> !sclReady);

endmodule

// File: tb/sim_sda_hold_setup_timer.sv
module sim_sda_hold_setup_timer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic extTiming = 1'b0;
  logic sclFall = 1'b0;
  logic txBit = 1'b1;
  logic setupClass = 1'b0;
  logic bitLoad = 1'b0;
  logic bitGo = 1'b0;
  logic sdaOut;
  logic sclReady;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sda_hold_setup_timer u0 (
    .clk(clk), .rst(rst), .extTiming(extTiming), .sclFall(sclFall),
    .txBit(txBit), .setupClass(setupClass), .bitLoad(bitLoad),
    .bitGo(bitGo), .sdaOut(sdaOut), .sclReady(sclReady)
  );

  // ext, setupClass, go gap (edges after fall), expected SDA edge, ready lag
  localparam int VEC [8][5] = '{
    '{0, 0,  0,  3,  0},
    '{0, 1,  0,  3,  0},
    '{1, 1,  0, 12, 11},
    '{1, 0,  0, 12,  0},
    '{0, 1,  5,  6,  0},
    '{1, 1, 15, 16, 11},
    '{1, 1, 11, 12, 11},
    '{0, 0,  2,  3,  0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual expired expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sdaEdge;
    int readyEdge;
    logic nb;
    logic cur;
    bit readySeen;

    // R1: reset state
    repeat (3) step();
    check(sdaOut == 1'b1, "R1 sda in reset", int'(sdaOut), 1);
    check(sclReady == 1'b0, "R1 ready in reset", int'(sclReady), 0);
    @(negedge clk); rst = 1'b0;
    repeat (2) step();
    check(sdaOut == 1'b1, "R1 sda after reset", int'(sdaOut), 1);
    check(sclReady == 1'b0, "R1 ready after reset", int'(sclReady), 0);

    // R7: go with nothing loaded
    @(negedge clk); bitGo = 1'b1;
    step();
    @(negedge clk); bitGo = 1'b0;
    repeat (5) step();
    check(sdaOut == 1'b1, "R7 sda after empty go", int'(sdaOut), 1);
    check(sclReady == 1'b0, "R7 ready after empty go", int'(sclReady), 0);

    // Vector table: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < 8; v++) begin
      nb = ~sdaOut;
      @(negedge clk);
      extTiming = VEC[v][0][0];
      setupClass = VEC[v][1][0];
      sclFall = 1'b1; bitLoad = 1'b1; txBit = nb;
      bitGo = (VEC[v][2] == 0);
      step();
      check(sclReady == 1'b0, "R8 ready dropped on fall", int'(sclReady), 0);
      sdaEdge = -1; readyEdge = -1;
      for (int k = 1; k <= 40; k++) begin
        @(negedge clk);
        sclFall = 1'b0; bitLoad = 1'b0;
        bitGo = (k == VEC[v][2]);
        step();
        if (sdaEdge < 0 && sdaOut == nb) sdaEdge = k;
        if (readyEdge < 0 && sclReady) readyEdge = k;
      end
      check(sdaEdge == VEC[v][3],
            (VEC[v][2] > 0) ? "R6 go-gated apply edge" : (VEC[v][0] != 0 ? "R3 ext hold edge" : "R2 std hold edge"),
            sdaEdge, VEC[v][3]);
      check(readyEdge - sdaEdge == VEC[v][4],
            (VEC[v][4] > 0) ? "R4 ext setup lag" : "R5 ready with sda",
            readyEdge - sdaEdge, VEC[v][4]);
    end

    // R9: last load before go wins
    cur = sdaOut;
    @(negedge clk);
    extTiming = 1'b0; setupClass = 1'b0;
    sclFall = 1'b1; bitLoad = 1'b1; txBit = cur;
    step();
    @(negedge clk); sclFall = 1'b0; txBit = ~cur;
    step();
    @(negedge clk); bitLoad = 1'b0; bitGo = 1'b1;
    step();
    @(negedge clk); bitGo = 1'b0;
    repeat (5) step();
    check(sdaOut == ~cur, "R9 latest load driven", int'(sdaOut), int'(~cur));
    check(sclReady == 1'b1, "R9 ready after apply", int'(sclReady), 1);

    // R8: second fall restarts the hold window
    cur = sdaOut;
    @(negedge clk);
    sclFall = 1'b1; bitLoad = 1'b1; txBit = ~cur; bitGo = 1'b1;
    step();
    @(negedge clk); sclFall = 1'b0; bitLoad = 1'b0; bitGo = 1'b0;
    step();
    @(negedge clk); sclFall = 1'b1;
    step();
    check(sdaOut == cur, "R8 sda held at restart", int'(sdaOut), int'(cur));
    sdaEdge = -1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk); sclFall = 1'b0;
      step();
      if (sdaEdge < 0 && sdaOut == ~cur) sdaEdge = k;
    end
    check(sdaEdge == 3, "R8 hold restarted by second fall", sdaEdge, 3);

    // R10: fall during setup window abandons it
    cur = sdaOut;
    @(negedge clk);
    extTiming = 1'b1; setupClass = 1'b1;
    sclFall = 1'b1; bitLoad = 1'b1; txBit = ~cur; bitGo = 1'b1;
    step();
    readySeen = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      sclFall = (k == 16); bitLoad = 1'b0; bitGo = 1'b0;
      step();
      if (sclReady) readySeen = 1'b1;
    end
    check(sdaOut == ~cur, "R10 sda kept applied bit", int'(sdaOut), int'(~cur));
    check(readySeen == 1'b0, "R10 ready never offered", int'(readySeen), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule